// File: doc/BRIEF.md
# Bus Target Pass-Through Bridge

This block is the target-side engine that connects host bus data phases to a local add-on bus. Two small FIFOs sit between the two sides. Write data from the host goes into a write FIFO, which the add-on drains at its own pace. Read data is supplied by the add-on through a read FIFO, and the block hands it to the host. The host side uses a reduced target handshake: active-low frame, initiator-ready, target-ready and stop, a shared address/data input, a command bit and active-low byte enables. Everything runs on one clock.

On the address phase the block captures an aligned burst address, the transfer direction and a 2-bit window number. It then raises a busy indication toward the add-on. The burst address moves forward one word with every completed data phase. Target-ready follows FIFO occupancy. When the write FIFO is full, or the read FIFO stays empty too long, the block does not insert wait states. It drives stop without target-ready, which releases the bus. A read-request output tells the add-on when to supply words, either one word at a time or filling ahead when prefetch is enabled. Any read words left over at the end of a transaction are discarded.

Top module: `pt_target_bridge`

## Requirements
- R1: After reset, trdy_n and stop_n are high, pt_busy and rd_req are low and wf_empty is high; whenever pt_busy is low, trdy_n and stop_n are high.
- R2: A clock edge with pt_busy low and frame_n low is an address phase. In the following cycle pt_busy is high, pt_wr equals cmd_wr (1 = write), pt_addr equals ad_in with bits 1:0 cleared, and pt_region equals ad_in bits 21:20.
- R3: A data phase completes on an edge where trdy_n and irdy_n are both low. Each completed phase raises pt_addr by 4, so during the k-th phase of a burst (counting from 0) pt_addr is the captured address plus 4k.
- R4: pt_region holds its value for as long as pt_busy stays high.
- R5: During a write, trdy_n is low whenever the write FIFO (8 entries by default) is not full. Each completed phase stores ad_in and be_n. The add-on sees them in arrival order on wf_data and wf_be_n, and advances with wf_pop. A pop while wf_empty is high is ignored.
- R6: During a write with the write FIFO full, stop_n is low and trdy_n is high. Once stop_n is low, it stays low until the edge after frame_n is sampled high, and the transaction then ends.
- R7: During a read, trdy_n is low only while the read FIFO holds at least one word, and ad_out shows the oldest stored word. A word pushed with rf_push is available in the cycle after its push.
- R8: Consecutive read phases complete on consecutive cycles while the read FIFO stays non-empty and irdy_n stays low.
- R9: During a read, if the read FIFO stays empty, stop_n goes low (with trdy_n high) in data cycle WAIT_LIMIT (default 8) after the address phase. Data cycles are counted from 0, and the count restarts whenever the FIFO holds data.
- R10: rd_req is high only during a read. With prefetch_en low it is high only while the read FIFO is empty. With prefetch_en high it is high while the read FIFO (4 entries by default) is not full.
- R11: When a transaction ends, words left in the read FIFO are discarded. The next read shows trdy_n high until new data is pushed.
- R12: trdy_n and stop_n are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Initiator frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cmd_wr | input | 1 | Direction at the address phase, 1 = write |
| ad_in | input | 32 | Address in the address phase, write data in data phases |
| be_n | input | 4 | Active-low byte enables of the current phase |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target disconnect request, active low |
| ad_out | output | 32 | Read data, the oldest word in the read FIFO |
| prefetch_en | input | 1 | Fill the read FIFO ahead of demand |
| pt_busy | output | 1 | A transaction is in progress and needs service |
| pt_wr | output | 1 | Direction of the current transaction |
| pt_region | output | 2 | Window number of the current transaction |
| pt_addr | output | 32 | Address of the current data phase |
| wf_pop | input | 1 | Add-on takes the head of the write FIFO |
| wf_data | output | 32 | Head word of the write FIFO |
| wf_be_n | output | 4 | Byte enables stored with the head word |
| wf_empty | output | 1 | Write FIFO is empty |
| rf_push | input | 1 | Add-on stores rf_data in the read FIFO |
| rf_data | input | 32 | Read word supplied by the add-on |
| rf_full | output | 1 | Read FIFO is full |
| rd_req | output | 1 | The add-on should supply read data |

## Verification
The assertions assume a well-behaved initiator. It opens a transaction only from idle. It keeps frame_n low until the last phase, or until it sees stop. After a disconnect it drives frame_n high. The bench drives every input on the falling edge and never breaks these rules. The same stimulus is applied to both prefetch settings. Burst lengths run from one word up to past the write FIFO depth, so both full and empty FIFO edges are reached inside legal transactions.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;

    localparam int PT_REGION_W = 2;

    typedef logic [PT_REGION_W-1:0] pt_region_t;

    typedef enum logic [1:0] {
        PT_IDLE = 2'd0,
        PT_DATA = 2'd1,
        PT_DISC = 2'd2
    } pt_state_e;

endpackage

// File: rtl/pt_fifo.sv
`timescale 1ns/1ps
module pt_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t     st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic         push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        empty   = (st_q.cnt == '0);
        full    = (st_q.cnt == CW'(DEPTH));
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wptr = bump(st_q.wptr);
            if (pop_ok)  st_d.rptr = bump(st_q.rptr);
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
        rdata = mem[st_q.rptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wptr] <= wdata;
    end

endmodule

// File: rtl/pt_burst_addr.sv
`timescale 1ns/1ps
module pt_burst_addr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] ALIGN_MASK = AW'(STEP - 1);

    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load)     addr_d = load_val & ~ALIGN_MASK;
        else if (adv) addr_d = addr_q + AW'(STEP);
        addr = addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

endmodule

// File: rtl/pt_target_bridge.sv
`timescale 1ns/1ps
module pt_target_bridge
    import pt_pkg::*;
#(
    parameter int DW         = 32,
    parameter int ADDR_W     = 32,
    parameter int WF_DEPTH   = 8,
    parameter int RF_DEPTH   = 4,
    parameter int WAIT_LIMIT = 8,
    parameter int REGION_LSB = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] ad_in,
    input  logic [DW/8-1:0]   be_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic [DW-1:0]     ad_out,
    input  logic              prefetch_en,
    output logic              pt_busy,
    output logic              pt_wr,
    output logic [1:0]        pt_region,
    output logic [ADDR_W-1:0] pt_addr,
    input  logic              wf_pop,
    output logic [DW-1:0]     wf_data,
    output logic [DW/8-1:0]   wf_be_n,
    output logic              wf_empty,
    input  logic              rf_push,
    input  logic [DW-1:0]     rf_data,
    output logic              rf_full,
    output logic              rd_req
);
    localparam int BEW   = DW / 8;
    localparam int WFW   = DW + BEW;
    localparam int WCW   = $clog2(WAIT_LIMIT + 1);
    localparam int STEP  = BEW;

    typedef struct packed {
        pt_state_e   state;
        logic        wr;
        pt_region_t  region;
        logic [WCW-1:0] wait_cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic           trdy_w, stop_w, phase_done, end_w;
    logic           wf_push, wf_full, rf_pop, rf_empty;
    logic           addr_load, addr_adv;
    logic [WFW-1:0] wf_head;

    always_comb begin
        ctl_d      = ctl_q;
        trdy_w     = 1'b0;
        stop_w     = 1'b0;
        end_w      = 1'b0;
        addr_load  = 1'b0;
        rd_req     = 1'b0;

        if (ctl_q.state == PT_DATA) begin
            if (ctl_q.wr) begin
                trdy_w = !wf_full;
                stop_w = wf_full;
            end else begin
                trdy_w = !rf_empty;
                stop_w = rf_empty && (ctl_q.wait_cnt == WCW'(WAIT_LIMIT));
                rd_req = !rf_full && (prefetch_en || rf_empty);
            end
        end else if (ctl_q.state == PT_DISC) begin
            stop_w = 1'b1;
        end

        phase_done = trdy_w && !irdy_n;
        addr_adv   = phase_done;
        wf_push    = phase_done && ctl_q.wr;
        rf_pop     = phase_done && !ctl_q.wr;

        case (ctl_q.state)
            PT_IDLE: begin
                if (!frame_n) begin
                    ctl_d.state    = PT_DATA;
                    ctl_d.wr       = cmd_wr;
                    ctl_d.region   = ad_in[REGION_LSB +: PT_REGION_W];
                    ctl_d.wait_cnt = '0;
                    addr_load      = 1'b1;
                end
            end
            PT_DATA: begin
                if (!ctl_q.wr && rf_empty) begin
                    if (ctl_q.wait_cnt != WCW'(WAIT_LIMIT))
                        ctl_d.wait_cnt = ctl_q.wait_cnt + WCW'(1);
                end else begin
                    ctl_d.wait_cnt = '0;
                end
                if (phase_done && frame_n) begin
                    ctl_d.state = PT_IDLE;
                    end_w       = 1'b1;
                end else if (stop_w) begin
                    ctl_d.state = PT_DISC;
                end
            end
            PT_DISC: begin
                if (frame_n) begin
                    ctl_d.state = PT_IDLE;
                    end_w       = 1'b1;
                end
            end
            default: ctl_d.state = PT_IDLE;
        endcase

        trdy_n    = !trdy_w;
        stop_n    = !stop_w;
        pt_busy   = (ctl_q.state != PT_IDLE);
        pt_wr     = ctl_q.wr;
        pt_region = ctl_q.region;
        wf_data   = wf_head[DW-1:0];
        wf_be_n   = wf_head[WFW-1:DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: PT_IDLE, wr: 1'b0, region: '0, wait_cnt: '0};
        else        ctl_q <= ctl_d;
    end

    pt_burst_addr #(.AW(ADDR_W), .STEP(STEP)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_val (ad_in),
        .adv      (addr_adv),
        .addr     (pt_addr)
    );

    pt_fifo #(.W(WFW), .DEPTH(WF_DEPTH)) wfifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (1'b0),
        .push  (wf_push),
        .wdata ({be_n, ad_in[DW-1:0]}),
        .pop   (wf_pop),
        .rdata (wf_head),
        .empty (wf_empty),
        .full  (wf_full)
    );

    pt_fifo #(.W(DW), .DEPTH(RF_DEPTH)) rfifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (end_w),
        .push  (rf_push),
        .wdata (rf_data),
        .pop   (rf_pop),
        .rdata (ad_out),
        .empty (rf_empty),
        .full  (rf_full)
    );

endmodule

// File: rtl/pt_target_bridge_chk.sv
`timescale 1ns/1ps
module pt_target_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              irdy_n,
    input logic              trdy_n,
    input logic              stop_n,
    input logic              prefetch_en,
    input logic              pt_busy,
    input logic              pt_wr,
    input logic [1:0]        pt_region,
    input logic [ADDR_W-1:0] pt_addr,
    input logic              rd_req,
    input logic              rf_empty_i
);
    // R12
    trdy_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!trdy_n && !stop_n));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pt_busy |-> (trdy_n && stop_n));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && !frame_n) |=> (pt_addr == $past(pt_addr) + ADDR_W'(STEP)));

    // R6
    disc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && !frame_n) |=> !stop_n);

    // R4
    region_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_busy && $past(pt_busy)) |-> $stable(pt_region));

    // R7
    rd_trdy_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_busy && !pt_wr && !trdy_n) |-> !rf_empty_i);

    // R10
    nopf_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !prefetch_en) |-> rf_empty_i);

    // R10
    req_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (pt_busy && !pt_wr));

endmodule

bind pt_target_bridge pt_target_bridge_chk #(.ADDR_W(ADDR_W), .STEP(DW/8)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .trdy_n      (trdy_n),
    .stop_n      (stop_n),
    .prefetch_en (prefetch_en),
    .pt_busy     (pt_busy),
    .pt_wr       (pt_wr),
    .pt_region   (pt_region),
    .pt_addr     (pt_addr),
    .rd_req      (rd_req),
    .rf_empty_i  (rf_empty)
);

// File: tb/pt_target_bridge_tb.sv
`timescale 1ns/1ps
module pt_target_bridge_tb_top;
    localparam int WFD   = 8;
    localparam int RFD   = 4;
    localparam int WLIM  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, cmd_wr = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  be_n = '1;
    logic        trdy_n, stop_n;
    logic [31:0] ad_out;
    logic        prefetch_en = 1'b0;
    logic        pt_busy, pt_wr;
    logic [1:0]  pt_region;
    logic [31:0] pt_addr;
    logic        wf_pop = 1'b0;
    logic [31:0] wf_data;
    logic [3:0]  wf_be_n;
    logic        wf_empty;
    logic        rf_push = 1'b0;
    logic [31:0] rf_data = '0;
    logic        rf_full, rd_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pt_target_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .cmd_wr(cmd_wr), .ad_in(ad_in), .be_n(be_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .ad_out(ad_out), .prefetch_en(prefetch_en),
        .pt_busy(pt_busy), .pt_wr(pt_wr), .pt_region(pt_region),
        .pt_addr(pt_addr), .wf_pop(wf_pop), .wf_data(wf_data),
        .wf_be_n(wf_be_n), .wf_empty(wf_empty), .rf_push(rf_push),
        .rf_data(rf_data), .rf_full(rf_full), .rd_req(rd_req)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] wpat(input logic [31:0] base, input int i);
        return base ^ (32'(i) * 32'h0101_0101) ^ 32'hA500_0000;
    endfunction

    function automatic logic [31:0] rpat(input int t, input int i);
        return 32'h5A00_0000 + 32'(t) * 32'h100 + 32'(i);
    endfunction

    task automatic addr_phase(input logic [31:0] a, input logic wr);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; cmd_wr = wr; ad_in = a;
        @(posedge clk);
    endtask

    task automatic wr_burst(input logic [31:0] base, input int n);
        bit stopped = 1'b0;
        logic [31:0] al = base & ~32'h3;
        addr_phase(base, 1'b1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ad_in = wpat(base, i); be_n = 4'(i); irdy_n = 1'b0;
            frame_n = (i == n - 1);
            #2;
            if (i == 0) begin
                check(pt_busy && pt_wr, "R2 busy/dir", {30'd0, pt_busy, pt_wr}, 32'h3);
                check(pt_region == base[21:20], "R2 region", 32'(pt_region), 32'(base[21:20]));
            end
            if (i < WFD) begin
                check(!trdy_n && stop_n, "R5 write accepted", {30'd0, trdy_n, stop_n}, 32'h1);
                check(pt_addr == al + 32'(4 * i), "R3 burst addr", pt_addr, al + 32'(4 * i));
            end else begin
                check(trdy_n && !stop_n, "R6 full disconnect", {30'd0, trdy_n, stop_n}, 32'h2);
                stopped = 1'b1;
                break;
            end
        end
        if (stopped) begin
            @(negedge clk);
            frame_n = 1'b1; irdy_n = 1'b0;
            #2 check(!stop_n && trdy_n, "R6 stop held", {30'd0, trdy_n, stop_n}, 32'h2);
        end
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1;
        #2 check(!pt_busy && stop_n && trdy_n, "R1 idle after end", {29'd0, pt_busy, trdy_n, stop_n}, 32'h3);
        for (int j = 0; j < ((n < WFD) ? n : WFD); j++) begin
            @(negedge clk);
            wf_pop = 1'b1;
            #2;
            check(!wf_empty && wf_data == wpat(base, j), "R5 write data order", wf_data, wpat(base, j));
            check(wf_be_n == 4'(j), "R5 write byte enables", 32'(wf_be_n), 32'(j));
        end
        @(negedge clk);
        wf_pop = 1'b1;
        #2 check(wf_empty, "R5 drained", 32'(wf_empty), 32'h1);
        @(negedge clk);
        wf_pop = 1'b0;
        #2 check(wf_empty, "R5 empty pop ignored", 32'(wf_empty), 32'h1);
    endtask

    task automatic rd_stream(input logic [31:0] base, input int n, input bit pf, input int t);
        logic [31:0] al = base & ~32'h3;
        prefetch_en = pf;
        addr_phase(base, 1'b0);
        @(negedge clk);
        irdy_n = 1'b0; frame_n = 1'b0; rf_push = 1'b1; rf_data = rpat(t, 0);
        #2;
        check(trdy_n && stop_n, "R7 no data yet", {30'd0, trdy_n, stop_n}, 32'h3);
        check(rd_req, "R10 request when empty", 32'(rd_req), 32'h1);
        check(pt_region == base[21:20] && !pt_wr, "R2 read capture", 32'(pt_region), 32'(base[21:20]));
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            rf_push = (c < n); rf_data = rpat(t, c); frame_n = (c == n);
            #2;
            check(!trdy_n, "R8 consecutive read ready", 32'(trdy_n), 32'h0);
            check(ad_out == rpat(t, c - 1), "R7 read data", ad_out, rpat(t, c - 1));
            check(pt_addr == al + 32'(4 * (c - 1)), "R3 read burst addr", pt_addr, al + 32'(4 * (c - 1)));
            check(rd_req == pf, "R10 request with data present", 32'(rd_req), 32'(pf));
        end
        @(negedge clk);
        rf_push = 1'b0; irdy_n = 1'b1; frame_n = 1'b1;
        #2 check(!pt_busy && trdy_n, "R1 read end idle", {30'd0, pt_busy, trdy_n}, 32'h1);
    endtask

    task automatic rd_timeout(input logic [31:0] base);
        addr_phase(base, 1'b0);
        for (int k = 0; k < WLIM; k++) begin
            @(negedge clk);
            irdy_n = 1'b0; frame_n = 1'b0;
            #2 check(trdy_n && stop_n, "R11 R9 waiting, no stale data", {30'd0, trdy_n, stop_n}, 32'h3);
        end
        @(negedge clk);
        #2 check(trdy_n && !stop_n, "R9 wait limit disconnect", {30'd0, trdy_n, stop_n}, 32'h2);
        @(negedge clk);
        frame_n = 1'b1;
        #2 check(!stop_n, "R6 stop held after timeout", 32'(stop_n), 32'h0);
        @(negedge clk);
        irdy_n = 1'b1;
        #2 check(!pt_busy && stop_n, "R1 idle after timeout", {30'd0, pt_busy, stop_n}, 32'h1);
    endtask

    task automatic rd_leftover(input logic [31:0] base, input int k, input bit pf, input int t);
        prefetch_en = pf;
        addr_phase(base, 1'b0);
        for (int j = 0; j < k; j++) begin
            @(negedge clk);
            irdy_n = 1'b1; frame_n = 1'b0; rf_push = 1'b1; rf_data = rpat(t, j);
            #2;
            check(stop_n, "R9 no timeout with data", 32'(stop_n), 32'h1);
            check(rd_req == (pf ? (j < RFD) : (j == 0)), "R10 prefetch request",
                  32'(rd_req), 32'(pf ? (j < RFD) : (j == 0)));
        end
        @(negedge clk);
        rf_push = 1'b0; irdy_n = 1'b0; frame_n = 1'b1;
        #2;
        check(!trdy_n && ad_out == rpat(t, 0), "R7 head word", ad_out, rpat(t, 0));
        check(rf_full == (k >= RFD), "R10 read FIFO level", 32'(rf_full), 32'(k >= RFD));
        @(negedge clk);
        irdy_n = 1'b1;
        #2 check(!pt_busy, "R11 ended", 32'(pt_busy), 32'h0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(trdy_n && stop_n && !pt_busy && wf_empty && !rd_req, "R1 reset state",
              {27'd0, trdy_n, stop_n, pt_busy, wf_empty, rd_req}, 32'h1A);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 1; n <= 10; n++)
            wr_burst((32'(n % 4) << 20) | (32'(n) << 12) | 32'(n % 4), n);
        for (int pf = 0; pf < 2; pf++)
            for (int n = 1; n <= 6; n++)
                rd_stream((32'((n + pf) % 4) << 20) | (32'(n) << 8) | 32'h2, n, pf[0], n + 8 * pf);
        for (int pf = 0; pf < 2; pf++)
            for (int k = 1; k <= 6; k++) begin
                rd_leftover(32'h0010_4000 + 32'(k << 4), k, pf[0], 40 + k + 8 * pf);
                rd_timeout(32'h0020_8000 + 32'(k << 4));
            end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule